// File: doc/BRIEF.md
# Single-Precision Result Packer

This block sits at the back end of a floating-point datapath. It takes a result that is still unpacked and turns it into a 32-bit IEEE single-precision word, with overflow, underflow and inexact flags. The unpacked result is a class code, a sign, an unbiased exponent, a mantissa that carries the leading one explicitly, and a separate sticky bit. The mantissa is 26 bits wide: bit 25 is the leading one, bits 24:2 are the fraction, bit 1 is the guard bit and bit 0 is the round bit.

The packer biases the exponent. Results that are too small for a normal encoding are shifted right into subnormal form. The packer then rounds in one of four modes and repairs exponent carries that rounding produces. On overflow it saturates to infinity or to the largest finite value, depending on the mode and the sign. NaN payloads pass through with the quiet bit forced on.

The unit is pipelined in two stages and accepts one operand per clock. A valid flag travels with each operand.

Top module: `sp_result_packer`

## Requirements
- R1: With class code 0 (zero), the output is a zero carrying the input sign, and no flag is set.
- R2: With class code 2 (infinity), the output has exponent field 0xFF and fraction 0, carries the input sign, and sets no flag.
- R3: With class code 3 (NaN), the exponent field is 0xFF and the fraction is in_mant[24:2] with bit 22 forced to 1. The sign passes through and no flag is set.
- R4: With class code 1 (finite), a result that needs no rounding is packed as sign in bit 31, in_exp+127 in bits 30:23 and in_mant[24:2] in bits 22:0.
- R5: Rounding mode 0 rounds to nearest with ties to even, 1 rounds toward zero, 2 rounds toward plus infinity and 3 rounds toward minus infinity. Inexact is set exactly when any of guard, round or sticky survives alignment.
- R6: When rounding a normal result carries out to 2.0, the exponent field goes up by one and the fraction field is 0.
- R7: When in_exp+127 is zero or less, the mantissa is shifted right by 1-(in_exp+127) places, the bits shifted out go into sticky, and the exponent field is 0.
- R8: When rounding a subnormal carries into bit 23, the output is the smallest normal (exponent field 1, fraction 0), and underflow is not raised.
- R9: A result that stays subnormal raises underflow exactly when it is inexact or when uf_trap_en is 1. Underflow is raised only with exponent field 0.
- R10: When the rounded biased exponent reaches 255 or more, overflow and inexact are raised. The output is then infinity in mode 0, in mode 2 for a positive result and in mode 3 for a negative result. In every other case it is the largest finite value (exponent 254, fraction all ones) with the result's sign.
- R11: out_valid rises exactly two cycles after in_valid, one result per cycle. Reset clears out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_class | input | 2 | 0 zero, 1 finite, 2 infinity, 3 NaN |
| in_sign | input | 1 | Sign of the result |
| in_exp | input | 10 | Unbiased exponent, two's complement |
| in_mant | input | 26 | Leading one, 23 fraction bits, guard, round |
| in_sticky | input | 1 | OR of all bits below round |
| rnd_mode | input | 2 | Rounding mode (see R5) |
| uf_trap_en | input | 1 | Underflow trap enabled |
| out_valid | output | 1 | Packed result present |
| out_word | output | 32 | Packed single-precision word |
| out_overflow | output | 1 | Overflow flag |
| out_underflow | output | 1 | Underflow flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
The stimulus table tries each rounding mode on mantissas whose low bits are exact, an exact tie with an even and with an odd last bit, a round bit alone, and a sticky bit alone. These cases tell the nearest, directed and truncating modes apart. Exponents just past the top of the range are run under every mode and sign to separate the infinity outcome from the largest-finite outcome. Exponents at and below the subnormal boundary, with and without the trap enable, separate the exact, inexact, promoted and fully flushed results. Three operands sent back to back show that results come out in order, one per cycle.

// File: rtl/sp_pack_pkg.sv
package sp_pack_pkg;

    localparam int FRAC_W   = 23;
    localparam int MANT_W   = FRAC_W + 3;
    localparam int IN_EXP_W = 10;
    localparam int BEXP_W   = IN_EXP_W + 2;
    localparam int EXP_F_W  = 8;
    localparam int WORD_W   = 1 + EXP_F_W + FRAC_W;
    localparam int EXP_BIAS = 127;
    localparam int EXP_TOP  = 255;
    localparam int SH_MAX   = MANT_W + 1;
    localparam int SH_W     = $clog2(2 * MANT_W);

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_FIN  = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } cls_e;

    typedef enum logic [1:0] {
        RND_NEAR = 2'd0,
        RND_ZERO = 2'd1,
        RND_UP   = 2'd2,
        RND_DOWN = 2'd3
    } rnd_e;

    typedef struct packed {
        cls_e                     cls;
        logic                     sign;
        logic                     subn;
        logic signed [BEXP_W-1:0] bexp;
        logic [FRAC_W:0]          kept;
        logic [1:0]               gr;
        logic                     stk;
        rnd_e                     mode;
        logic                     trap;
        logic [FRAC_W-1:0]        nan_frac;
    } aligned_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              ovf;
        logic              unf;
        logic              inx;
    } packed_t;

    function automatic logic round_inc(rnd_e mode, logic sign, logic lsb,
                                       logic g, logic r, logic s);
        logic lost;
        lost = g | r | s;
        case (mode)
            RND_NEAR: round_inc = g & (r | s | lsb);
            RND_ZERO: round_inc = 1'b0;
            RND_UP:   round_inc = lost & ~sign;
            default:  round_inc = lost & sign;
        endcase
    endfunction

    function automatic logic goes_to_inf(rnd_e mode, logic sign);
        case (mode)
            RND_NEAR: goes_to_inf = 1'b1;
            RND_ZERO: goes_to_inf = 1'b0;
            RND_UP:   goes_to_inf = ~sign;
            default:  goes_to_inf = sign;
        endcase
    endfunction

endpackage

// File: rtl/sp_align.sv
module sp_align
    import sp_pack_pkg::*;
(
    input  logic [1:0]          cls,
    input  logic                sign,
    input  logic [IN_EXP_W-1:0] exp_in,
    input  logic [MANT_W-1:0]   mant,
    input  logic                sticky,
    input  logic [1:0]          mode,
    input  logic                trap,
    output aligned_t            al
);

    logic signed [BEXP_W-1:0] ext_exp;
    logic signed [BEXP_W-1:0] bexp;
    logic signed [BEXP_W-1:0] amt;
    logic [SH_W-1:0]          sh;
    logic [2*MANT_W-1:0]      wide;
    logic [MANT_W-1:0]        shifted;
    logic                     lost;
    logic                     subn;

    always_comb begin
        ext_exp = {{(BEXP_W-IN_EXP_W){exp_in[IN_EXP_W-1]}}, exp_in};
        bexp    = ext_exp + $signed(BEXP_W'(EXP_BIAS));
        subn    = (bexp <= $signed(BEXP_W'(0)));
        amt     = $signed(BEXP_W'(1)) - bexp;
        if (!subn)
            sh = '0;
        else if (amt > $signed(BEXP_W'(SH_MAX)))
            sh = SH_W'(SH_MAX);
        else
            sh = amt[SH_W-1:0];
        wide    = {mant, {MANT_W{1'b0}}} >> sh;
        shifted = wide[2*MANT_W-1:MANT_W];
        lost    = |wide[MANT_W-1:0];

        al.cls      = cls_e'(cls);
        al.sign     = sign;
        al.subn     = subn;
        al.bexp     = bexp;
        al.kept     = shifted[MANT_W-1:2];
        al.gr       = shifted[1:0];
        al.stk      = sticky | lost;
        al.mode     = rnd_e'(mode);
        al.trap     = trap;
        al.nan_frac = mant[MANT_W-2:2] | {1'b1, {(FRAC_W-1){1'b0}}};
    end

endmodule

// File: rtl/sp_round_pack.sv
module sp_round_pack
    import sp_pack_pkg::*;
(
    input  aligned_t al,
    output packed_t  res
);

    logic                     inc;
    logic                     inx;
    logic [FRAC_W+1:0]        rounded;
    logic signed [BEXP_W-1:0] e2;

    always_comb begin
        inx     = al.gr[1] | al.gr[0] | al.stk;
        inc     = round_inc(al.mode, al.sign, al.kept[0], al.gr[1], al.gr[0], al.stk);
        rounded = {1'b0, al.kept} + (FRAC_W+2)'(inc);
        e2      = al.bexp + $signed({{(BEXP_W-1){1'b0}}, rounded[FRAC_W+1]});
        res     = '0;

        case (al.cls)
            CLS_ZERO: res.word = {al.sign, {(WORD_W-1){1'b0}}};
            CLS_INF:  res.word = {al.sign, {EXP_F_W{1'b1}}, {FRAC_W{1'b0}}};
            CLS_NAN:  res.word = {al.sign, {EXP_F_W{1'b1}}, al.nan_frac};
            default: begin
                res.inx = inx;
                if (al.subn) begin
                    if (rounded[FRAC_W]) begin
                        res.word = {al.sign, EXP_F_W'(1), {FRAC_W{1'b0}}};
                    end else begin
                        res.word = {al.sign, {EXP_F_W{1'b0}}, rounded[FRAC_W-1:0]};
                        res.unf  = inx | al.trap;
                    end
                end else if (e2 >= $signed(BEXP_W'(EXP_TOP))) begin
                    res.ovf = 1'b1;
                    res.inx = 1'b1;
                    if (goes_to_inf(al.mode, al.sign))
                        res.word = {al.sign, {EXP_F_W{1'b1}}, {FRAC_W{1'b0}}};
                    else
                        res.word = {al.sign, EXP_F_W'(EXP_TOP-1), {FRAC_W{1'b1}}};
                end else begin
                    res.word = {al.sign, e2[EXP_F_W-1:0], rounded[FRAC_W-1:0]};
                end
            end
        endcase
    end

endmodule

// File: rtl/sp_result_packer.sv
module sp_result_packer
    import sp_pack_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [1:0]          in_class,
    input  logic                in_sign,
    input  logic [IN_EXP_W-1:0] in_exp,
    input  logic [MANT_W-1:0]   in_mant,
    input  logic                in_sticky,
    input  logic [1:0]          rnd_mode,
    input  logic                uf_trap_en,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_word,
    output logic                out_overflow,
    output logic                out_underflow,
    output logic                out_inexact
);

    aligned_t al_d, al_q;
    logic     v_q;
    packed_t  res_d, res_q;
    logic     vo_q;

    sp_align u_align (
        .cls    (in_class),
        .sign   (in_sign),
        .exp_in (in_exp),
        .mant   (in_mant),
        .sticky (in_sticky),
        .mode   (rnd_mode),
        .trap   (uf_trap_en),
        .al     (al_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q  <= 1'b0;
            al_q <= '0;
        end else begin
            v_q  <= in_valid;
            al_q <= al_d;
        end
    end

    sp_round_pack u_round (
        .al  (al_q),
        .res (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vo_q  <= 1'b0;
            res_q <= '0;
        end else begin
            vo_q  <= v_q;
            res_q <= res_d;
        end
    end

    assign out_valid     = vo_q;
    assign out_word      = res_q.word;
    assign out_overflow  = res_q.ovf;
    assign out_underflow = res_q.unf;
    assign out_inexact   = res_q.inx;

endmodule

// File: rtl/sp_result_packer_chk.sv
module sp_result_packer_chk
    import sp_pack_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        in_class,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_word,
    input logic              out_overflow,
    input logic              out_underflow,
    input logic              out_inexact
);

    // R11
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid);

    // R11
    valid_origin_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 !out_valid);

    // R10
    overflow_inexact_chk: assert property (@(posedge clk) disable iff (rst)
        out_overflow |-> out_inexact);

    // R10
    overflow_target_chk: assert property (@(posedge clk) disable iff (rst)
        out_overflow |-> (out_word[30:23] == 8'hFF || out_word[30:0] == 31'h7F7FFFFF));

    // R9
    underflow_expzero_chk: assert property (@(posedge clk) disable iff (rst)
        out_underflow |-> (out_word[30:23] == 8'h00));

    // R3
    nan_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_class == 2'd3) |=> ##1 (out_word[30:22] == 9'h1FF));

    // R1
    zero_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_class == 2'd0) |=> ##1 (!out_overflow && !out_underflow && !out_inexact));

endmodule

bind sp_result_packer sp_result_packer_chk u_chk (.*);

// File: tb/sp_result_packer_test.sv
module sp_result_packer_test;

    typedef struct packed {
        logic [1:0]  cls;
        logic        sign;
        logic [9:0]  expo;
        logic [25:0] mant;
        logic        stk;
        logic [1:0]  mode;
        logic        trap;
        logic [31:0] word;
        logic [2:0]  flg;   // {overflow, underflow, inexact}
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b1, 10'h000, 26'h2000000, 1'b0, 2'd0, 1'b0, 32'h80000000, 3'b000}, // R1
        '{2'd2, 1'b0, 10'h000, 26'h2000000, 1'b0, 2'd0, 1'b0, 32'h7F800000, 3'b000}, // R2
        '{2'd3, 1'b1, 10'h000, 26'h2000004, 1'b0, 2'd0, 1'b0, 32'hFFC00001, 3'b000}, // R3
        '{2'd1, 1'b0, 10'h000, 26'h2000000, 1'b0, 2'd0, 1'b0, 32'h3F800000, 3'b000}, // R4
        '{2'd1, 1'b0, 10'h000, 26'h2000002, 1'b0, 2'd0, 1'b0, 32'h3F800000, 3'b001}, // R5 tie even
        '{2'd1, 1'b0, 10'h000, 26'h2000006, 1'b0, 2'd0, 1'b0, 32'h3F800002, 3'b001}, // R5 tie odd
        '{2'd1, 1'b0, 10'h000, 26'h2000002, 1'b1, 2'd0, 1'b0, 32'h3F800001, 3'b001}, // R5 above half
        '{2'd1, 1'b0, 10'h000, 26'h2000003, 1'b1, 2'd1, 1'b0, 32'h3F800000, 3'b001}, // R5 trunc
        '{2'd1, 1'b0, 10'h000, 26'h2000001, 1'b0, 2'd2, 1'b0, 32'h3F800001, 3'b001}, // R5 +inf pos
        '{2'd1, 1'b1, 10'h000, 26'h2000001, 1'b0, 2'd2, 1'b0, 32'hBF800000, 3'b001}, // R5 +inf neg
        '{2'd1, 1'b1, 10'h000, 26'h2000001, 1'b0, 2'd3, 1'b0, 32'hBF800001, 3'b001}, // R5 -inf neg
        '{2'd1, 1'b0, 10'h000, 26'h2000000, 1'b1, 2'd3, 1'b0, 32'h3F800000, 3'b001}, // R5 -inf pos
        '{2'd1, 1'b0, 10'h000, 26'h3FFFFFE, 1'b0, 2'd0, 1'b0, 32'h40000000, 3'b001}, // R6
        '{2'd1, 1'b0, 10'h07F, 26'h3FFFFFE, 1'b0, 2'd0, 1'b0, 32'h7F800000, 3'b101}, // R10 carry
        '{2'd1, 1'b0, 10'h080, 26'h2000000, 1'b0, 2'd1, 1'b0, 32'h7F7FFFFF, 3'b101}, // R10
        '{2'd1, 1'b1, 10'h080, 26'h2000000, 1'b0, 2'd2, 1'b0, 32'hFF7FFFFF, 3'b101}, // R10
        '{2'd1, 1'b0, 10'h080, 26'h2000000, 1'b0, 2'd2, 1'b0, 32'h7F800000, 3'b101}, // R10
        '{2'd1, 1'b1, 10'h080, 26'h2000000, 1'b0, 2'd3, 1'b0, 32'hFF800000, 3'b101}, // R10
        '{2'd1, 1'b0, 10'h080, 26'h2000000, 1'b0, 2'd3, 1'b0, 32'h7F7FFFFF, 3'b101}, // R10
        '{2'd1, 1'b0, 10'h381, 26'h2000000, 1'b0, 2'd0, 1'b0, 32'h00400000, 3'b000}, // R7 exact
        '{2'd1, 1'b0, 10'h381, 26'h2000000, 1'b0, 2'd0, 1'b1, 32'h00400000, 3'b010}, // R9 trap
        '{2'd1, 1'b0, 10'h380, 26'h2000004, 1'b0, 2'd0, 1'b0, 32'h00200000, 3'b011}, // R9 inexact
        '{2'd1, 1'b0, 10'h381, 26'h3FFFFFE, 1'b0, 2'd0, 1'b0, 32'h00800000, 3'b001}, // R8
        '{2'd1, 1'b0, 10'h338, 26'h2000000, 1'b0, 2'd2, 1'b0, 32'h00000001, 3'b011}, // R7 flush up
        '{2'd1, 1'b1, 10'h338, 26'h2000000, 1'b0, 2'd0, 1'b0, 32'h80000000, 3'b011}, // R7 flush
        '{2'd1, 1'b0, 10'h382, 26'h2000000, 1'b0, 2'd0, 1'b0, 32'h00800000, 3'b000}  // R4 min normal
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  in_class;
    logic        in_sign;
    logic [9:0]  in_exp;
    logic [25:0] in_mant;
    logic        in_sticky;
    logic [1:0]  rnd_mode;
    logic        uf_trap_en;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_overflow;
    logic        out_underflow;
    logic        out_inexact;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    sp_result_packer uut (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_class      (in_class),
        .in_sign       (in_sign),
        .in_exp        (in_exp),
        .in_mant       (in_mant),
        .in_sticky     (in_sticky),
        .rnd_mode      (rnd_mode),
        .uf_trap_en    (uf_trap_en),
        .out_valid     (out_valid),
        .out_word      (out_word),
        .out_overflow  (out_overflow),
        .out_underflow (out_underflow),
        .out_inexact   (out_inexact)
    );

    task automatic check(string req, logic [35:0] act, logic [35:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic drive(vec_t v);
        in_valid   = 1'b1;
        in_class   = v.cls;
        in_sign    = v.sign;
        in_exp     = v.expo;
        in_mant    = v.mant;
        in_sticky  = v.stk;
        rnd_mode   = v.mode;
        uf_trap_en = v.trap;
    endtask

    function automatic logic [35:0] expect_of(vec_t v);
        return {1'b1, v.word, v.flg};
    endfunction

    function automatic logic [35:0] seen();
        return {out_valid, out_word, out_overflow, out_underflow, out_inexact};
    endfunction

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_class = '0; in_sign = 1'b0; in_exp = '0;
        in_mant = '0; in_sticky = 1'b0; rnd_mode = '0; uf_trap_en = 1'b0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 reset", seen(), 36'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            @(negedge clk);
            in_valid = 1'b0;
            @(negedge clk);
            check($sformatf("vector %0d (see table tag)", i), seen(), expect_of(VEC[i]));
        end

        // R11 back-to-back throughput
        @(negedge clk); drive(VEC[3]);
        @(negedge clk); drive(VEC[5]);
        @(negedge clk); drive(VEC[13]);
        check("R11 stream first", seen(), expect_of(VEC[3]));
        @(negedge clk); in_valid = 1'b0;
        check("R11 stream second", seen(), expect_of(VEC[5]));
        @(negedge clk);
        check("R11 stream third", seen(), expect_of(VEC[13]));
        @(negedge clk);
        check("R11 idle", {35'h0, out_valid}, 36'h0);

        // R9 trap enable ignored for a promoted subnormal (R8)
        @(negedge clk); drive(VEC[22]); uf_trap_en = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        check("R8 promote with trap", seen(), expect_of(VEC[22]));

        // R11 reset mid-flight
        @(negedge clk); drive(VEC[3]);
        @(negedge clk); in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        check("R11 reset flush", {35'h0, out_valid}, 36'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R11 after flush", {35'h0, out_valid}, 36'h0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule